// File: doc/BRIEF.md
# Logarithmic-Depth Fixed-Priority Arbiter

This block chooses one winner among a parameterised number of requesters that compete for a shared resource. Requester indices run from 0 to NUM_REQ-1, and the lowest active index always wins. It drives a one-hot grant vector and a flag that is high whenever any requester is being served.

The grant decision needs to know, for each position, whether any lower-numbered line is active. That term comes from a parallel-prefix OR network. Each stage ORs the running vector with a copy of itself shifted up by a power of two, so the gate depth grows with ceil(log2 NUM_REQ) and not with NUM_REQ.

A parameter adds an output register that is cleared by a synchronous active-high reset. This register suits paths where the grant must leave the cycle in a flop. The block has no state machine. Its only sequential element is the optional output register, which has two conditions: held in reset, or loading the new decision on each rising clock edge.

Top module: `prio_tree_arbiter`

## Requirements
- R1: NUM_REQ can be any value of 1 or more, including values that are not a power of two. Bit i of req_i and bit i of gnt_o both belong to requester i.
- R2: No more than one bit of gnt_o is high at any time.
- R3: A grant bit is never high while the matching request bit is low.
- R4: gnt_o bit i is 1 exactly when req_i bit i is 1 and every req_i bit below i is 0.
- R5: any_o is the OR of all request bits. With no request active, gnt_o is all zeros and any_o is 0.
- R6: Whenever at least one request bit is high, exactly one grant bit is high.
- R7: With REG_OUT = 0, gnt_o and any_o follow req_i within the same cycle and no clock edge is involved.
- R8: With REG_OUT = 1, gnt_o and any_o show the decision for the req_i value captured at the most recent rising edge. They stay unchanged between edges.
- R9: With REG_OUT = 1, a rising edge with rst high clears gnt_o and any_o to zero whatever the requests are. With REG_OUT = 0, rst has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| req_i | input | NUM_REQ | Request lines, bit i from requester i |
| gnt_o | output | NUM_REQ | One-hot grant, bit i to requester i |
| any_o | output | 1 | High when some request is being granted |

## Verification
With five requesters, every possible request pattern is applied. This shows whether the decode selects the lowest set bit in all positions and for all combinations of higher bits. A 37-requester instance is driven with dense random words, sparse masked words and single-bit words. Dense words stress the deep prefix stages across the non-power-of-two top. Single bits show whether any position is shadowed by a wrongly shifted stage. A registered 12-requester instance receives active requests while reset is held, and again just after each edge. This separates a correct one-cycle latency and reset clear from a leaky or unregistered output.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // number of doubling stages needed to cover n positions
    function automatic int tree_depth(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/arb_prefix_or.sv
module arb_prefix_or #(
    parameter int NUM_REQ = 8
) (
    input  logic [NUM_REQ-1:0] bits_i,
    output logic [NUM_REQ-1:0] incl_o
);
    localparam int DEPTH = arb_pkg::tree_depth(NUM_REQ);

    // lvl[k] bit i holds the OR of bits i-2^k+1 .. i
    logic [NUM_REQ-1:0] lvl [DEPTH+1];

    assign lvl[0] = bits_i;

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        localparam int DIST = 1 << k;
        if (DIST < NUM_REQ) begin : g_span
            // zeros shift in from below: positions under index 0 count as idle
            assign lvl[k+1] = lvl[k] | (lvl[k] << DIST);
        end else begin : g_pass
            assign lvl[k+1] = lvl[k];
        end
    end

    assign incl_o = lvl[DEPTH];

endmodule

// File: rtl/arb_grant_sel.sv
module arb_grant_sel #(
    parameter int NUM_REQ = 8
) (
    input  logic [NUM_REQ-1:0] req_i,
    input  logic [NUM_REQ-1:0] incl_i,
    output logic [NUM_REQ-1:0] gnt_o,
    output logic               any_o
);
    if (NUM_REQ == 1) begin : g_single
        assign gnt_o = req_i;
    end else begin : g_multi
        // a position is blocked when the inclusive OR one place below is set
        logic [NUM_REQ-1:0] blocked;
        assign blocked = {incl_i[NUM_REQ-2:0], 1'b0};
        assign gnt_o   = req_i & ~blocked;
    end

    assign any_o = incl_i[NUM_REQ-1];

endmodule

// File: rtl/arb_out_stage.sv
module arb_out_stage #(
    parameter int NUM_REQ = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] gnt_d,
    input  logic               any_d,
    output logic [NUM_REQ-1:0] gnt_q,
    output logic               any_q
);
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                gnt_q <= '0;
                any_q <= 1'b0;
            end else begin
                gnt_q <= gnt_d;
                any_q <= any_d;
            end
        end
    end else begin : g_comb
        assign gnt_q = gnt_d;
        assign any_q = any_d;
    end

endmodule

// File: rtl/prio_tree_arbiter.sv
module prio_tree_arbiter #(
    parameter int NUM_REQ = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req_i,
    output logic [NUM_REQ-1:0] gnt_o,
    output logic               any_o
);
    logic [NUM_REQ-1:0] incl;
    logic [NUM_REQ-1:0] gnt_d;
    logic               any_d;

    arb_prefix_or #(.NUM_REQ(NUM_REQ)) u_tree (
        .bits_i (req_i),
        .incl_o (incl)
    );

    arb_grant_sel #(.NUM_REQ(NUM_REQ)) u_sel (
        .req_i  (req_i),
        .incl_i (incl),
        .gnt_o  (gnt_d),
        .any_o  (any_d)
    );

    arb_out_stage #(.NUM_REQ(NUM_REQ), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst   (rst),
        .gnt_d (gnt_d),
        .any_d (any_d),
        .gnt_q (gnt_o),
        .any_q (any_o)
    );

endmodule

// File: rtl/prio_tree_arbiter_chk.sv
module prio_tree_arbiter_chk #(
    parameter int NUM_REQ = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_REQ-1:0] req_i,
    input logic [NUM_REQ-1:0] gnt_o,
    input logic               any_o
);
    logic [NUM_REQ-1:0] req_ref;
    logic               valid;

    if (REG_OUT) begin : g_seq
        logic [NUM_REQ-1:0] req_seen;
        logic               armed;
        always_ff @(posedge clk) begin
            req_seen <= req_i;
            armed    <= !rst;
        end
        assign req_ref = req_seen;
        assign valid   = armed;

        // R9
        reset_clear_chk: assert property (@(posedge clk)
            rst |=> (gnt_o == '0 && !any_o));
    end else begin : g_cmb
        assign req_ref = req_i;
        assign valid   = 1'b1;
    end

    // R2
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o));

    // R3
    no_idle_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> ((gnt_o & ~req_ref) == '0));

    // R5
    any_match_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> (any_o == (|req_ref)));

    // R4
    lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && (|req_ref)) |-> (((gnt_o - 1'b1) & req_ref) == '0));

    // R6
    some_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && (|req_ref)) |-> (gnt_o != '0));

endmodule

bind prio_tree_arbiter prio_tree_arbiter_chk #(
    .NUM_REQ (NUM_REQ),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .req_i (req_i),
    .gnt_o (gnt_o),
    .any_o (any_o)
);

// File: tb/prio_tree_arbiter_tb.sv
module prio_tree_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 5;
    localparam int NB = 37;
    localparam int NC = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NA-1:0] req_a = '0;
    logic [NB-1:0] req_b = '0;
    logic [NC-1:0] req_c = '0;
    logic [NA-1:0] gnt_a;
    logic [NB-1:0] gnt_b;
    logic [NC-1:0] gnt_c;
    logic any_a, any_b, any_c;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_tree_arbiter #(.NUM_REQ(NA), .REG_OUT(1'b0)) u_dut (
        .clk(clk), .rst(rst), .req_i(req_a), .gnt_o(gnt_a), .any_o(any_a));
    prio_tree_arbiter #(.NUM_REQ(NB), .REG_OUT(1'b0)) u_dut_big (
        .clk(clk), .rst(rst), .req_i(req_b), .gnt_o(gnt_b), .any_o(any_b));
    prio_tree_arbiter #(.NUM_REQ(NC), .REG_OUT(1'b1)) u_dut_reg (
        .clk(clk), .rst(rst), .req_i(req_c), .gnt_o(gnt_c), .any_o(any_c));

    // linear scan from index 0 upward
    function automatic logic [63:0] scan_ref(input logic [63:0] r, input int n);
        for (int i = 0; i < n; i++)
            if (r[i]) return 64'd1 << i;
        return 64'd0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic eval_comb(input string who, input logic [63:0] g, input logic a,
                             input logic [63:0] r, input int n);
        chk({who, " R4 R7 grant"}, g, scan_ref(r, n));
        chk({who, " R5 any"}, {63'd0, a}, {63'd0, (r != 0)});
        chk({who, " R2 onehot"}, {63'd0, ($countones(g) <= 1)}, 64'd1);
        chk({who, " R3 idle"}, g & ~r, 64'd0);
        chk({who, " R6 some"}, {63'd0, (r == 0) || (g != 0)}, 64'd1);
    endtask

    // one cycle: check registered output, apply new stimulus, check combinational outputs
    task automatic step(input logic nrst, input logic [NA-1:0] a,
                        input logic [NB-1:0] b, input logic [NC-1:0] c);
        logic [63:0] exp_c;
        @(negedge clk);
        exp_c = rst ? 64'd0 : scan_ref({52'd0, req_c}, NC);
        chk(rst ? "R9 reg reset" : "R8 reg grant", {52'd0, gnt_c}, exp_c);
        chk("R8 R9 reg any", {63'd0, any_c}, {63'd0, exp_c != 0});
        rst   = nrst;
        req_a = a;
        req_b = b;
        req_c = c;
        #1;
        // R8: no change between edges
        chk("R8 hold", {52'd0, gnt_c}, exp_c);
        // R9: combinational instances ignore rst; R1: odd width instance
        eval_comb("R1 R9 n5", {59'd0, gnt_a}, any_a, {59'd0, req_a}, NA);
        eval_comb("R1 n37", {27'd0, gnt_b}, any_b, {27'd0, req_b}, NB);
    endtask

    function automatic logic [NB-1:0] rnd_b();
        return NB'({$urandom, $urandom});
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset held with active requests
        for (int i = 0; i < 4; i++) step(1'b1, 5'h1f, '1, 12'hfff);
        step(1'b0, 5'h00, '0, 12'h000);
        // exhaustive small instance; walking single bits in the wide one
        for (int p = 0; p < 32; p++)
            step(1'b0, NA'(p), NB'(1) << (p % NB), NC'($urandom));
        for (int p = 0; p < NB; p++)
            step(1'b0, NA'(p), NB'(1) << p, NC'(1) << (p % NC));
        // dense and sparse random words
        for (int t = 0; t < 1500; t++) begin
            logic [NB-1:0] b;
            b = rnd_b();
            if (t % 3 == 1) b = b & rnd_b() & rnd_b();
            if (t % 3 == 2) b = b & rnd_b() & rnd_b() & rnd_b() & rnd_b();
            step(1'b0, NA'($urandom), b, NC'($urandom) & NC'($urandom));
        end
        // reset mid-run
        step(1'b1, 5'h04, rnd_b(), 12'h800);
        step(1'b1, 5'h10, rnd_b(), 12'h040);
        step(1'b0, 5'h18, NB'(1) << (NB-1), 12'h800);
        step(1'b0, 5'h00, '0, 12'h000);
        step(1'b0, 5'h00, '0, 12'h000);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule